// File: doc/BRIEF.md
# Pre-Trade Position Limit Gate

This block sits in an order path just ahead of the routing logic and decides, for every order, whether it may pass. It holds a signed running position for each instrument and a table of per-instrument limits that can be written at any time. For each order it forms the position the instrument would have if the order were filled: the current position plus the quantity for a buy, or minus the quantity for a sell. If the magnitude of that projected position stays strictly below the instrument's limit, the order is forwarded and the new position is stored in the same clock edge. Otherwise the order is discarded and a one-cycle alert is raised.

The gate is a two-stage pipeline with a fixed latency and takes a new order every cycle. Because the position is read and written in the same decision stage, two orders for the same instrument on consecutive cycles each see the effect of the one before. The output stream has a ready input. When it is deasserted the gate holds its result and stops taking new orders.

Top module: `position_limit_gate`

## Requirements
- R1: After reset every position is zero and every limit is zero, so every order is rejected until a limit is written. `outValid` and `limitAlert` are low, and `ordReady` is high.
- R2: An order whose projected position has a magnitude strictly below its instrument's limit is forwarded. `outValid` is high with unchanged instrument, side and quantity in the cycle that follows the second clock edge after the input handshake.
- R3: An order whose projected position has a magnitude equal to or above the limit produces no output. `limitAlert` is high for exactly that one cycle, with the same latency as R2.
- R4: `ordSide` = 0 is a buy and adds the quantity to the position. `ordSide` = 1 is a sell and subtracts it. The position changes only when an order is forwarded.
- R5: An order that enters the cycle after another order for the same instrument is checked against the position already updated by the earlier order.
- R6: A limit write applies to orders whose input handshake falls in a later cycle. An order accepted at the input in the same cycle as the write uses the old limit.
- R7: Positions and limits of different instruments are independent.
- R8: While the output is empty or being taken, `ordReady` stays high, so one order can enter in every cycle.
- R9: While `outValid` is high and `outReady` is low, the output fields stay stable, no order is lost, and `ordReady` drops once the first stage is occupied.
- R10: Limits up to at least 10,000 are supported, and positions down to -9,999 and up to +9,999 are held exactly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ordValid | input | 1 | Incoming order valid |
| ordReady | output | 1 | Gate can take an order |
| ordInst | input | $clog2(NUM_INST) | Instrument index |
| ordSide | input | 1 | 0 buy, 1 sell |
| ordQty | input | QTY_W | Order quantity |
| outValid | output | 1 | Forwarded order valid |
| outReady | input | 1 | Routing logic takes the order |
| outInst | output | $clog2(NUM_INST) | Forwarded instrument |
| outSide | output | 1 | Forwarded side |
| outQty | output | QTY_W | Forwarded quantity |
| limWrEn | input | 1 | Limit table write strobe |
| limWrInst | input | $clog2(NUM_INST) | Instrument whose limit is written |
| limWrValue | input | LIM_W | New limit |
| limitAlert | output | 1 | One-cycle pulse per rejected order |

## Verification
Two things can fall in the same cycle. A limit write can coincide with the input handshake of an order for the same instrument, and a position update can coincide with the check of the next order for that instrument. The bench provokes the first by driving the write and the order on one edge. It expects the old limit to decide that order and the new limit to decide the next one. It provokes the second by sending three orders to one instrument on consecutive cycles, sized so that the second is rejected and the third is accepted only if each check saw the preceding update.

// File: rtl/plg_pkg.sv
package plg_pkg;

  // Strobes issued by the control unit to the datapath each cycle.
  typedef struct packed {
    logic capture;  // load stage A with the incoming order and its limit
    logic decide;   // stage A order is being judged this cycle
    logic commit;   // judged order passes: store position, load output
    logic drop;     // judged order fails the limit check
  } gate_strobe_t;

endpackage

// File: rtl/plg_datapath.sv
module plg_datapath
  import plg_pkg::*;
#(
  parameter int NUM_INST = 8,
  parameter int QTY_W    = 16,
  parameter int LIM_W    = 16,
  localparam int IDX_W   = (NUM_INST > 1) ? $clog2(NUM_INST) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  gate_strobe_t     st,
  input  logic [IDX_W-1:0] inInst,
  input  logic             inSide,
  input  logic [QTY_W-1:0] inQty,
  input  logic             limWrEn,
  input  logic [IDX_W-1:0] limWrInst,
  input  logic [LIM_W-1:0] limWrValue,
  output logic             passCheck,
  output logic [IDX_W-1:0] outInst,
  output logic             outSide,
  output logic [QTY_W-1:0] outQty
);

  // An accepted position is strictly below the limit in magnitude, so one
  // sign bit above the limit width holds it exactly.
  localparam int POS_W  = LIM_W + 1;
  localparam int WIDE_W = ((POS_W > QTY_W) ? POS_W : QTY_W) + 1;

  logic        [LIM_W-1:0] limTab [NUM_INST];
  logic signed [POS_W-1:0] posTab [NUM_INST];

  // Stage A registers
  logic [IDX_W-1:0] aInst;
  logic             aSide;
  logic [QTY_W-1:0] aQty;
  logic [LIM_W-1:0] aLim;

  // Decision-stage arithmetic
  logic signed [POS_W-1:0]  posRd;
  logic signed [WIDE_W-1:0] curWide;
  logic signed [WIDE_W-1:0] qtyWide;
  logic signed [WIDE_W-1:0] projWide;
  logic        [WIDE_W-1:0] projMag;
  logic        [WIDE_W-1:0] limWide;
  logic signed [POS_W-1:0]  posNext;

  // Per-instrument limit and position registers
  for (genvar g = 0; g < NUM_INST; g++) begin : g_inst
    always_ff @(posedge clk) begin
      if (!rstN) begin
        limTab[g] <= '0;
      end else if (limWrEn && (limWrInst == IDX_W'(g))) begin
        limTab[g] <= limWrValue;
      end
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        posTab[g] <= '0;
      end else if (st.commit && (aInst == IDX_W'(g))) begin
        posTab[g] <= posNext;
      end
    end
  end

  // Stage A: the limit is sampled together with the order, so a table write
  // in the entry cycle only reaches later orders.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      aInst <= '0;
      aSide <= 1'b0;
      aQty  <= '0;
      aLim  <= '0;
    end else if (st.capture) begin
      aInst <= inInst;
      aSide <= inSide;
      aQty  <= inQty;
      aLim  <= limTab[inInst];
    end
  end

  // Decision: read the live position, project it, compare its magnitude.
  always_comb begin
    posRd    = posTab[aInst];
    curWide  = WIDE_W'(posRd);
    qtyWide  = $signed({{(WIDE_W - QTY_W){1'b0}}, aQty});
    projWide = aSide ? (curWide - qtyWide) : (curWide + qtyWide);
    projMag  = projWide[WIDE_W-1] ? $unsigned(-projWide) : $unsigned(projWide);
    limWide  = {{(WIDE_W - LIM_W){1'b0}}, aLim};
    passCheck = (projMag < limWide);
    posNext  = projWide[POS_W-1:0];
  end

  // Output register, loaded only by a committed order.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      outInst <= '0;
      outSide <= 1'b0;
      outQty  <= '0;
    end else if (st.commit) begin
      outInst <= aInst;
      outSide <= aSide;
      outQty  <= aQty;
    end
  end

endmodule

// File: rtl/plg_control.sv
module plg_control
  import plg_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         inValid,
  output logic         inReady,
  input  logic         outReady,
  output logic         outValid,
  input  logic         passCheck,
  output gate_strobe_t st,
  output logic         alert
);

  logic aValid;
  logic stall;

  always_comb begin
    stall      = outValid && !outReady;
    inReady    = !aValid || !stall;
    st.capture = inValid && inReady;
    st.decide  = aValid && !stall;
    st.commit  = st.decide && passCheck;
    st.drop    = st.decide && !passCheck;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      aValid   <= 1'b0;
      outValid <= 1'b0;
      alert    <= 1'b0;
    end else begin
      if (st.capture) begin
        aValid <= 1'b1;
      end else if (st.decide) begin
        aValid <= 1'b0;
      end

      if (st.commit) begin
        outValid <= 1'b1;
      end else if (outReady) begin
        outValid <= 1'b0;
      end

      alert <= st.drop;
    end
  end

endmodule

// File: rtl/position_limit_gate.sv
module position_limit_gate
  import plg_pkg::*;
#(
  parameter int NUM_INST = 8,
  parameter int QTY_W    = 16,
  parameter int LIM_W    = 16,
  localparam int IDX_W   = (NUM_INST > 1) ? $clog2(NUM_INST) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             ordValid,
  output logic             ordReady,
  input  logic [IDX_W-1:0] ordInst,
  input  logic             ordSide,
  input  logic [QTY_W-1:0] ordQty,
  output logic             outValid,
  input  logic             outReady,
  output logic [IDX_W-1:0] outInst,
  output logic             outSide,
  output logic [QTY_W-1:0] outQty,
  input  logic             limWrEn,
  input  logic [IDX_W-1:0] limWrInst,
  input  logic [LIM_W-1:0] limWrValue,
  output logic             limitAlert
);

  gate_strobe_t strobes;
  logic         passCheck;

  plg_control u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .inValid   (ordValid),
    .inReady   (ordReady),
    .outReady  (outReady),
    .outValid  (outValid),
    .passCheck (passCheck),
    .st        (strobes),
    .alert     (limitAlert)
  );

  plg_datapath #(
    .NUM_INST (NUM_INST),
    .QTY_W    (QTY_W),
    .LIM_W    (LIM_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .st         (strobes),
    .inInst     (ordInst),
    .inSide     (ordSide),
    .inQty      (ordQty),
    .limWrEn    (limWrEn),
    .limWrInst  (limWrInst),
    .limWrValue (limWrValue),
    .passCheck  (passCheck),
    .outInst    (outInst),
    .outSide    (outSide),
    .outQty     (outQty)
  );

endmodule

// File: rtl/position_limit_gate_chk.sv
module position_limit_gate_chk #(
  parameter int NUM_INST = 8,
  parameter int QTY_W    = 16,
  localparam int IDX_W   = (NUM_INST > 1) ? $clog2(NUM_INST) : 1
) (
  input logic             clk,
  input logic             rstN,
  input logic             ordValid,
  input logic             ordReady,
  input logic             outValid,
  input logic             outReady,
  input logic [IDX_W-1:0] outInst,
  input logic             outSide,
  input logic [QTY_W-1:0] outQty,
  input logic             limitAlert
);

  // R3: a rejected order never shows up on the output
  a_r3_alert_excludes_out: assert property (@(posedge clk) disable iff (!rstN)
    limitAlert |-> !outValid);

  // R9: a stalled output holds its fields
  a_r9_hold_when_stalled: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outInst) && $stable(outSide) && $stable(outQty)));

  // R8: an empty output never blocks the input
  a_r8_ready_when_clear: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> ordReady);

  // R2: an unstalled order yields an output or an alert one edge later
  a_r2_fixed_latency: assert property (@(posedge clk) disable iff (!rstN)
    (ordValid && ordReady) ##1 (!outValid || outReady) |=> (outValid || limitAlert));

endmodule

bind position_limit_gate position_limit_gate_chk #(
  .NUM_INST (NUM_INST),
  .QTY_W    (QTY_W)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .ordValid   (ordValid),
  .ordReady   (ordReady),
  .outValid   (outValid),
  .outReady   (outReady),
  .outInst    (outInst),
  .outSide    (outSide),
  .outQty     (outQty),
  .limitAlert (limitAlert)
);

// File: tb/position_limit_gate_tb.sv
module position_limit_gate_tb;

  localparam int NUM_INST = 8;
  localparam int QTY_W    = 16;
  localparam int LIM_W    = 16;
  localparam int IDX_W    = 3;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             ordValid = 1'b0;
  logic             ordReady;
  logic [IDX_W-1:0] ordInst = '0;
  logic             ordSide = 1'b0;
  logic [QTY_W-1:0] ordQty = '0;
  logic             outValid;
  logic             outReady = 1'b1;
  logic [IDX_W-1:0] outInst;
  logic             outSide;
  logic [QTY_W-1:0] outQty;
  logic             limWrEn = 1'b0;
  logic [IDX_W-1:0] limWrInst = '0;
  logic [LIM_W-1:0] limWrValue = '0;
  logic             limitAlert;

  int  checks = 0;
  int  errors = 0;
  bit  finished = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  position_limit_gate #(
    .NUM_INST (NUM_INST),
    .QTY_W    (QTY_W),
    .LIM_W    (LIM_W)
  ) u_dut (
    .clk        (clk),
    .rstN       (rstN),
    .ordValid   (ordValid),
    .ordReady   (ordReady),
    .ordInst    (ordInst),
    .ordSide    (ordSide),
    .ordQty     (ordQty),
    .outValid   (outValid),
    .outReady   (outReady),
    .outInst    (outInst),
    .outSide    (outSide),
    .outQty     (outQty),
    .limWrEn    (limWrEn),
    .limWrInst  (limWrInst),
    .limWrValue (limWrValue),
    .limitAlert (limitAlert)
  );

  // Vector: {isLimitWrite, inst[2:0], side, value[15:0], expectPass}
  localparam int NV = 13;
  localparam logic [21:0] VEC [NV] = '{
    {1'b0, 3'd0, 1'b0, 16'd1,     1'b0},  // R1 zero limit rejects
    {1'b1, 3'd0, 1'b0, 16'd100,   1'b0},  // limit inst0 = 100
    {1'b0, 3'd0, 1'b0, 16'd60,    1'b1},  // R2 buy -> 60
    {1'b0, 3'd0, 1'b0, 16'd40,    1'b0},  // R3 100 equals limit
    {1'b0, 3'd0, 1'b0, 16'd39,    1'b1},  // R4 -> 99
    {1'b0, 3'd0, 1'b1, 16'd150,   1'b1},  // R4 sell -> -51
    {1'b0, 3'd0, 1'b1, 16'd49,    1'b0},  // R3 -100 magnitude at limit
    {1'b1, 3'd3, 1'b0, 16'd10000, 1'b0},  // limit inst3 = 10000
    {1'b0, 3'd3, 1'b1, 16'd9999,  1'b1},  // R10 -> -9999
    {1'b0, 3'd3, 1'b1, 16'd1,     1'b0},  // R10 -10000 rejected
    {1'b0, 3'd3, 1'b0, 16'd19998, 1'b1},  // R10 -> +9999
    {1'b0, 3'd5, 1'b0, 16'd1,     1'b0},  // R7 inst5 still limit 0
    {1'b0, 3'd0, 1'b0, 16'd50,    1'b1}   // R7 inst0 at -51 -> -1
  };

  task automatic chk(input bit ok, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic writeLimit(input logic [IDX_W-1:0] inst, input logic [LIM_W-1:0] val);
    @(negedge clk);
    limWrEn = 1'b1; limWrInst = inst; limWrValue = val;
    @(negedge clk);
    limWrEn = 1'b0;
  endtask

  // Single order with an idle cycle around it; result sampled two edges later.
  task automatic sendOrder(input logic [IDX_W-1:0] inst, input logic side,
                           input logic [QTY_W-1:0] qty, input bit expPass, input string tag);
    @(negedge clk);
    ordValid = 1'b1; ordInst = inst; ordSide = side; ordQty = qty;
    chk(ordReady == 1'b1, {tag, " R8 ready"}, ordReady, 1);
    @(negedge clk);
    ordValid = 1'b0;
    @(negedge clk);
    chk(outValid == expPass, {tag, " outValid"}, outValid, expPass);
    chk(limitAlert == !expPass, {tag, " alert"}, limitAlert, !expPass);
    if (expPass) begin
      chk(outQty == qty && outInst == inst && outSide == side, {tag, " R2 fields"}, outQty, qty);
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(outValid == 1'b0, "R1 outValid after reset", outValid, 0);
    chk(limitAlert == 1'b0, "R1 alert after reset", limitAlert, 0);
    chk(ordReady == 1'b1, "R1 ready after reset", ordReady, 1);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][21]) begin
        writeLimit(VEC[i][20:18], VEC[i][16:1]);
      end else begin
        sendOrder(VEC[i][20:18], VEC[i][17], VEC[i][16:1], VEC[i][0],
                  $sformatf("vec%0d", i));
      end
    end

    // R5: three consecutive orders to inst1, limit 10: +6 pass, +6 fail, +3 pass
    writeLimit(3'd1, 16'd10);
    @(negedge clk);
    ordValid = 1'b1; ordInst = 3'd1; ordSide = 1'b0; ordQty = 16'd6;
    @(negedge clk);
    chk(ordReady == 1'b1, "R8 ready back-to-back", ordReady, 1);
    ordQty = 16'd6;
    @(negedge clk);
    chk(outValid == 1'b1 && outQty == 16'd6, "R5 first order forwarded", outQty, 6);
    chk(ordReady == 1'b1, "R8 ready third cycle", ordReady, 1);
    ordQty = 16'd3;
    @(negedge clk);
    ordValid = 1'b0;
    chk(outValid == 1'b0 && limitAlert == 1'b1, "R5 second order sees 6", limitAlert, 1);
    @(negedge clk);
    chk(outValid == 1'b1 && outQty == 16'd3 && limitAlert == 1'b0, "R5 third order sees 6", outQty, 3);

    // R6: limit write in the same cycle as the order entry uses the old limit
    @(negedge clk);
    ordValid = 1'b1; ordInst = 3'd2; ordSide = 1'b0; ordQty = 16'd5;
    limWrEn = 1'b1; limWrInst = 3'd2; limWrValue = 16'd100;
    @(negedge clk);
    ordValid = 1'b0; limWrEn = 1'b0;
    @(negedge clk);
    chk(limitAlert == 1'b1 && outValid == 1'b0, "R6 same-cycle write not applied", limitAlert, 1);
    sendOrder(3'd2, 1'b0, 16'd5, 1'b1, "R6 later order uses new limit");

    // R9: backpressure with inst1 at 9, limit 10: sell 1 then sell 2
    @(negedge clk);
    outReady = 1'b0;
    ordValid = 1'b1; ordInst = 3'd1; ordSide = 1'b1; ordQty = 16'd1;
    @(negedge clk);
    ordQty = 16'd2;
    @(negedge clk);
    chk(outValid == 1'b1 && outQty == 16'd1, "R9 first order presented", outQty, 1);
    chk(ordReady == 1'b0, "R9 ready drops when full", ordReady, 0);
    ordValid = 1'b0;
    @(negedge clk);
    chk(outValid == 1'b1 && outQty == 16'd1, "R9 output held", outQty, 1);
    outReady = 1'b1;
    @(negedge clk);
    chk(outValid == 1'b1 && outQty == 16'd2, "R9 second order not lost", outQty, 2);
    @(negedge clk);
    chk(outValid == 1'b0, "R9 output drains", outValid, 0);

    // R4: inst1 now 6 -> buy 3 gives 9 (pass), buy 1 gives 10 (fail)
    sendOrder(3'd1, 1'b0, 16'd3, 1'b1, "R4 position after sells");
    sendOrder(3'd1, 1'b0, 16'd1, 1'b0, "R4 position reaches limit");

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule